// File: doc/BRIEF.md
# Write-Protection Unlock Command Sequencer

This block sits in the write path of a byte-wide nonvolatile memory model and looks at every latched write (address and data) before it can reach the array. It keeps a protection flag. While the flag is clear, ordinary writes go straight through. While the flag is set, ordinary writes are refused. The only way to get data into the array is to send a three-write key first. That key opens a single page-load window, and the device locks again once the program cycle that follows the window has finished.

A longer six-write key arms a permanent clear of the flag. The clear takes effect only when the following program cycle reports completion on `prog_done`. Key bytes are never passed on to the array. The flag models nonvolatile storage only as a register with a reset value. A key that breaks off partway falls back as described in the requirements.

A write is consumed in the cycle where `wr_stb` is high. `wr_allow` and `wr_suppress` are combinational answers for that same write. The internal state and `prot_on` update at the clock edge that ends the cycle.

Top module: `wp_unlock_seq`

## Requirements
- R1: Reset behaviour.
  - After a synchronous active-low reset, `prot_on` is 0.
  - While `prot_on` is 0, a write that is not a key byte has `wr_allow`=1 and `wr_suppress`=0.
- R2: Only the address bits below the top bit (bits 14..0 with the default width) are compared against key addresses. Address bit 15 has no effect on matching.
- R3: Open key.
  - The open key is three writes in this order: data 0xAA at address 0x5555, data 0x55 at 0x2AAA, data 0xA0 at 0x5555.
  - Every write accepted as a key step has `wr_suppress`=1 and `wr_allow`=0.
  - Completing the open key sets `prot_on` from the next cycle and opens the page window.
- R4: Page window.
  - While the window is open, no key matching takes place.
  - The first PAGE_BYTES writes have `wr_allow`=1.
  - Any further write in the same window has `wr_allow`=0.
- R5: A `prog_done` pulse while the window is open closes the window. From then on, ordinary writes have `wr_allow`=0 while `prot_on` is 1.
- R6: In the first three key steps, a write that does not match the expected step returns the sequencer to idle. That write is then handled as an ordinary write: `wr_suppress`=0, and `wr_allow` equals the inverse of `prot_on`.
- R7: Clear key.
  - The clear key is six writes in this order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555.
  - After the sixth write, `prot_on` stays unchanged until a later `prog_done` pulse.
  - `prot_on` reads 0 in the cycle after that pulse.
- R8: Fallback after the third clear-key step.
  - When the sixth expected step (0x20@0x5555) fails, the last two accepted writes are reinterpreted as the first two steps of a fresh key.
  - In that case, 0xA0@0x5555 completes the open key.
  - In that case, 0x80@0x5555 counts as the third step of the clear key.
- R9: Completing the open key while a clear is pending cancels the pending clear.
- R10: With `wr_stb` low, `wr_allow` and `wr_suppress` are both 0.
- R11: A `prog_done` pulse with no window open and no clear pending leaves `prot_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One latched write is presented this cycle |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | DATA_W | Latched write data |
| prog_done | input | 1 | Pulse: the internal program cycle has finished |
| wr_allow | output | 1 | This write may be committed to the array |
| wr_suppress | output | 1 | This write is a key byte and must not be committed |
| prot_on | output | 1 | Protection flag |

## Verification
The bench builds the block with PAGE_BYTES=4 and the default 16-bit address and 8-bit data. This makes the page-limit refusal of R4 reachable after five window writes instead of 129. Directed sequences cover the following:
- the reset state;
- aborted keys, both unprotected and protected;
- a set top address bit inside a key;
- a clear key that falls back to an open key or restarts as a new clear key;
- a pending clear that is cancelled by a new open key.

A pseudo-random stretch of key-like and arbitrary writes with sporadic `prog_done` pulses is then compared, cycle by cycle, against a queue-based model of key prefixes.

// File: rtl/wp_seq_pkg.sv
// Shared types and key constants for the write-protection sequencer.
// Assumes key addresses are compared on 15 bits and key data on 8 bits.
package wp_seq_pkg;
    // Progress through the key: E* steps are common, D* steps are clear-only.
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_E1, SQ_E2, SQ_D3, SQ_D4, SQ_D5
    } seq_t;

    localparam logic [14:0] KEY_ADR_P  = 15'h5555;
    localparam logic [14:0] KEY_ADR_Q  = 15'h2AAA;
    localparam logic [7:0]  KEY_LEAD   = 8'hAA;
    localparam logic [7:0]  KEY_SECOND = 8'h55;
    localparam logic [7:0]  KEY_OPEN   = 8'hA0;
    localparam logic [7:0]  KEY_ARM    = 8'h80;
    localparam logic [7:0]  KEY_CLEAR  = 8'h20;
endpackage

// File: rtl/wp_key_match.sv
// Combinational key-step matcher. Given the current key progress and one
// write, it returns the next progress, whether the write is a key step, and
// whether the open or the clear key completes with it.
// Assumes the caller only applies the result while no page window is open.
module wp_key_match
    import wp_seq_pkg::*;
#(
    parameter int CMP_W  = 15,
    parameter int DATA_W = 8
) (
    input  seq_t              cur,
    input  logic [CMP_W-1:0]  adr,
    input  logic [DATA_W-1:0] dat,
    output seq_t              nxt,
    output logic              hit,
    output logic              open_done,
    output logic              clear_done
);
    logic is_lead, is_second, is_open, is_arm, is_clear;

    // Classify the write against every key byte.
    always_comb begin
        is_lead   = (adr == CMP_W'(KEY_ADR_P)) && (dat == DATA_W'(KEY_LEAD));
        is_second = (adr == CMP_W'(KEY_ADR_Q)) && (dat == DATA_W'(KEY_SECOND));
        is_open   = (adr == CMP_W'(KEY_ADR_P)) && (dat == DATA_W'(KEY_OPEN));
        is_arm    = (adr == CMP_W'(KEY_ADR_P)) && (dat == DATA_W'(KEY_ARM));
        is_clear  = (adr == CMP_W'(KEY_ADR_P)) && (dat == DATA_W'(KEY_CLEAR));
    end

    // Step transition; D5 falls back to the E2 interpretation on mismatch.
    always_comb begin
        nxt        = SQ_IDLE;
        hit        = 1'b0;
        open_done  = 1'b0;
        clear_done = 1'b0;
        case (cur)
            SQ_IDLE: if (is_lead)   begin nxt = SQ_E1; hit = 1'b1; end
            SQ_E1:   if (is_second) begin nxt = SQ_E2; hit = 1'b1; end
            SQ_E2: begin
                if (is_open)     begin hit = 1'b1; open_done = 1'b1; end
                else if (is_arm) begin nxt = SQ_D3; hit = 1'b1; end
            end
            SQ_D3:   if (is_lead)   begin nxt = SQ_D4; hit = 1'b1; end
            SQ_D4:   if (is_second) begin nxt = SQ_D5; hit = 1'b1; end
            SQ_D5: begin
                if (is_clear)     begin hit = 1'b1; clear_done = 1'b1; end
                else if (is_open) begin hit = 1'b1; open_done = 1'b1; end
                else if (is_arm)  begin nxt = SQ_D3; hit = 1'b1; end
            end
            default: nxt = SQ_IDLE;
        endcase
    end
endmodule

// File: rtl/wp_page_window.sv
// Page-load window after a completed open key. Counts loaded bytes and
// reports whether room is left. Assumes open_req never coincides with an
// already open window.
module wp_page_window #(
    parameter int PAGE_BYTES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_req,
    input  logic close_req,
    input  logic load_stb,
    output logic win_open,
    output logic room
);
    localparam int CNT_W = $clog2(PAGE_BYTES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Open/close the window and count bytes loaded into it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            cnt_q    <= '0;
        end else if (open_req) begin
            win_open <= 1'b1;
            cnt_q    <= '0;
        end else begin
            if (close_req) win_open <= 1'b0;
            if (load_stb)  cnt_q    <= cnt_q + 1'b1;
        end
    end

    // Room remains while fewer than PAGE_BYTES bytes were loaded.
    always_comb room = (cnt_q < CNT_W'(PAGE_BYTES));
endmodule

// File: rtl/wp_prot_flag.sv
// Protection flag with deferred clear. Setting is immediate; a clear is
// armed by the clear key and applied by the next program-done pulse.
// Assumes set_req wins over any simultaneous clear.
module wp_prot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic arm_req,
    input  logic done,
    output logic prot_on
);
    logic pend_q;

    // Track an armed-but-not-yet-applied clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (arm_req)          pend_q <= 1'b1;
        else if (set_req || done)  pend_q <= 1'b0;
    end

    // Hold the flag; model of the nonvolatile bit with reset value 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                prot_on <= 1'b0;
        else if (set_req)          prot_on <= 1'b1;
        else if (done && pend_q)   prot_on <= 1'b0;
    end
endmodule

// File: rtl/wp_unlock_seq.sv
// Top of the write-protection unlock sequencer. Judges each latched write
// (allow, suppress as key byte, or refuse) and keeps the protection flag.
// Assumes at most one write per cycle and a one-cycle prog_done pulse.
module wp_unlock_seq
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              wr_allow,
    output logic              wr_suppress,
    output logic              prot_on
);
    localparam int CMP_W = ADDR_W - 1;

    seq_t seq_q, seq_d;
    logic hit, open_done, clear_done;
    logic win_open, room, take;
    logic unused_top_bit;

    assign unused_top_bit = wr_addr[ADDR_W-1];

    wp_key_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_match (
        .cur        (seq_q),
        .adr        (wr_addr[CMP_W-1:0]),
        .dat        (wr_data),
        .nxt        (seq_d),
        .hit        (hit),
        .open_done  (open_done),
        .clear_done (clear_done)
    );

    // Writes outside a window are offered to the key matcher.
    always_comb take = wr_stb && !win_open;

    // Advance key progress on every matched-path write.
    always_ff @(posedge clk) begin
        if (!rst_n)    seq_q <= SQ_IDLE;
        else if (take) seq_q <= seq_d;
    end

    wp_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_req  (take && open_done),
        .close_req (prog_done),
        .load_stb  (wr_stb && win_open && room),
        .win_open  (win_open),
        .room      (room)
    );

    wp_prot_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (take && open_done),
        .arm_req (take && clear_done),
        .done    (prog_done),
        .prot_on (prot_on)
    );

    // Judge the current write.
    always_comb begin
        wr_allow    = 1'b0;
        wr_suppress = 1'b0;
        if (wr_stb) begin
            if (win_open) begin
                wr_allow = room;
            end else begin
                wr_suppress = hit;
                wr_allow    = !hit && !prot_on;
            end
        end
    end
endmodule

// File: rtl/wp_unlock_seq_chk.sv
// Assertion checker for wp_unlock_seq, attached by bind.
// Assumes the window state is brought in from the top's internal signal.
module wp_unlock_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prog_done,
    input logic              wr_allow,
    input logic              wr_suppress,
    input logic              prot_on,
    input logic              win_open
);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> (!wr_allow && !wr_suppress));

    // R3
    allow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_allow && wr_suppress));

    // R3
    key_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_suppress |-> (wr_data == DATA_W'(8'hAA) || wr_data == DATA_W'(8'h55) ||
                         wr_data == DATA_W'(8'hA0) || wr_data == DATA_W'(8'h80) ||
                         wr_data == DATA_W'(8'h20)));

    // R2
    key_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_suppress |-> (wr_addr[ADDR_W-2:0] == (ADDR_W-1)'(15'h5555) ||
                         wr_addr[ADDR_W-2:0] == (ADDR_W-1)'(15'h2AAA)));

    // R3
    prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_suppress && wr_data == DATA_W'(8'hA0)));

    // R7
    prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(prog_done));

    // R5
    locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !win_open) |-> !wr_allow);
endmodule

bind wp_unlock_seq wp_unlock_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .prog_done   (prog_done),
    .wr_allow    (wr_allow),
    .wr_suppress (wr_suppress),
    .prot_on     (prot_on),
    .win_open    (win_open)
);

// File: tb/sim_wp_unlock_seq.sv
module sim_wp_unlock_seq;
    localparam int PB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_done = 1'b0;
    logic        wr_allow, wr_suppress, prot_on;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wp_unlock_seq #(.ADDR_W(16), .DATA_W(8), .PAGE_BYTES(PB)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done), .wr_allow(wr_allow),
        .wr_suppress(wr_suppress), .prot_on(prot_on)
    );

    // Behavioural model state
    bit m_prot = 0, m_win = 0, m_pend = 0;
    int m_cnt = 0;
    logic [22:0] hist[$];
    logic [22:0] en_key[3];
    logic [22:0] ds_key[6];

    function automatic bit pref_of(logic [22:0] q[$], logic [22:0] k[], int n);
        if (q.size() > n) return 0;
        foreach (q[i]) if (q[i] != k[i]) return 0;
        return 1;
    endfunction

    task automatic run(input string tag, input bit stb, input logic [15:0] a,
                       input logic [7:0] d, input bit done);
        bit e_allow = 0, e_supp = 0, en = 0, clr = 0, any;
        logic [22:0] w;
        logic [22:0] cand[$];
        @(negedge clk);
        wr_stb = stb; wr_addr = a; wr_data = d; prog_done = done;
        if (stb) begin
            if (m_win) e_allow = (m_cnt < PB);
            else begin
                w = {a[14:0], d};
                cand = hist; cand.push_back(w);
                any = pref_of(cand, en_key, 3) || pref_of(cand, ds_key, 6);
                if (!any && hist.size() >= 3) begin
                    cand = hist[3:$]; cand.push_back(w);
                    any = pref_of(cand, en_key, 3) || pref_of(cand, ds_key, 6);
                end
                if (any) begin
                    e_supp = 1;
                    en  = (cand.size() == 3) && pref_of(cand, en_key, 3);
                    clr = (cand.size() == 6) && pref_of(cand, ds_key, 6);
                    if (en || clr) cand.delete();
                end else begin
                    cand.delete();
                    e_allow = !m_prot;
                end
                hist = cand;
            end
        end
        #1;
        tests++;
        if (wr_allow !== e_allow || wr_suppress !== e_supp || prot_on !== m_prot) begin
            fails++;
            $display("FAIL %s: allow=%0b exp %0b, suppress=%0b exp %0b, prot=%0b exp %0b",
                     tag, wr_allow, e_allow, wr_suppress, e_supp, prot_on, m_prot);
        end
        if (stb && m_win && m_cnt < PB) m_cnt++;
        if (done && m_win) m_win = 0;
        if (done && m_pend) begin m_prot = 0; m_pend = 0; end
        if (clr) m_pend = 1;
        if (en) begin m_prot = 1; m_win = 1; m_cnt = 0; m_pend = 0; end
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
        run(tag, 1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input string tag);
        run(tag, 1'b0, 16'h0, 8'h0, 1'b0);
    endtask

    task automatic done_pulse(input string tag);
        run(tag, 1'b0, 16'h0, 8'h0, 1'b1);
    endtask

    task automatic open_key(input string tag);
        wr(tag, 16'h5555, 8'hAA); wr(tag, 16'h2AAA, 8'h55); wr(tag, 16'h5555, 8'hA0);
    endtask

    task automatic clear_key(input string tag);
        wr(tag, 16'h5555, 8'hAA); wr(tag, 16'h2AAA, 8'h55); wr(tag, 16'h5555, 8'h80);
        wr(tag, 16'h5555, 8'hAA); wr(tag, 16'h2AAA, 8'h55); wr(tag, 16'h5555, 8'h20);
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        en_key = '{{15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'hA0}};
        ds_key = '{{15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h80},
                   {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h20}};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        idle("R1"); idle("R10");
        wr("R1", 16'h1234, 8'h5A);
        // R6: aborted key while unprotected
        wr("R6", 16'h5555, 8'hAA); wr("R6", 16'h1234, 8'h12);
        wr("R6", 16'h5555, 8'hAA); wr("R6", 16'h2AAA, 8'h55); wr("R6", 16'h5555, 8'h33);
        // R2, R3: open key with top address bit set on two steps
        wr("R2", 16'hD555, 8'hAA); wr("R2", 16'hAAAA, 8'h55); wr("R3", 16'h5555, 8'hA0);
        idle("R3");
        // R4: window loads, limit PB; key bytes inside are plain data
        wr("R4", 16'h5555, 8'hAA); wr("R4", 16'h0101, 8'h01);
        wr("R4", 16'h0102, 8'h02); wr("R4", 16'h0103, 8'h03);
        wr("R4", 16'h0104, 8'h04);
        // R5: close and stay locked
        done_pulse("R5"); idle("R5");
        wr("R5", 16'h0200, 8'h77);
        // R11: stray done
        done_pulse("R11"); idle("R11");
        // R6: aborted key while protected
        wr("R6", 16'h5555, 8'hAA); wr("R6", 16'h2AAA, 8'h55); wr("R6", 16'h5555, 8'h33);
        wr("R6", 16'h5555, 8'hAA); wr("R6", 16'h2AAB, 8'h55);
        // R8: clear key falls back into open key
        wr("R8", 16'h5555, 8'hAA); wr("R8", 16'h2AAA, 8'h55); wr("R8", 16'h5555, 8'h80);
        wr("R8", 16'h5555, 8'hAA); wr("R8", 16'h2AAA, 8'h55); wr("R8", 16'h5555, 8'hA0);
        wr("R8", 16'h0300, 8'h3C); done_pulse("R8");
        // R8 + R7: restart on 0x80 then finish clear
        wr("R8", 16'h5555, 8'hAA); wr("R8", 16'h2AAA, 8'h55); wr("R8", 16'h5555, 8'h80);
        wr("R8", 16'h5555, 8'hAA); wr("R8", 16'h2AAA, 8'h55); wr("R8", 16'h5555, 8'h80);
        wr("R7", 16'h5555, 8'hAA); wr("R7", 16'h2AAA, 8'h55); wr("R7", 16'h5555, 8'h20);
        idle("R7"); wr("R7", 16'h0400, 8'h11);
        done_pulse("R7"); idle("R7");
        wr("R7", 16'h0400, 8'h22);
        // R9: enable cancels pending clear
        open_key("R9"); done_pulse("R9");
        clear_key("R9"); open_key("R9");
        wr("R9", 16'h0500, 8'h44); done_pulse("R9");
        idle("R9"); done_pulse("R9"); idle("R9");
        wr("R9", 16'h0501, 8'h45);
        // Mixed pseudo-random stretch
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0, 3'd1: begin a = {lf[15], 15'h5555}; d = 8'hAA; end
                3'd2:       begin a = {lf[14], 15'h2AAA}; d = 8'h55; end
                3'd3:       begin a = 16'h5555; d = lf[3] ? 8'hA0 : 8'h80; end
                3'd4:       begin a = 16'h5555; d = 8'h20; end
                default:    begin a = lf; d = lf[11:4]; end
            endcase
            run("R6", lf[5] | lf[6], a, d, (lf[9:7] == 3'd0));
        end
        idle("R10");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule